// File: doc/BRIEF.md
# Register Pointer-Status Tracker

This block keeps a small set of status bits for every entry of a general-purpose register file. The bits record whether the register's current value has already been checked as a memory address. When an instruction uses a register as a load, store or fetch address, the tracker answers at once with one of three outcomes:

- proceed,
- stall while a translation check runs,
- raise a protection trap.

It also watches every register writeback and updates the bits according to the class of the writing instruction.

The check runs through a request/response port. A request carries the register index and the access kind and is held until it is accepted. Some time later a single response bit says whether the access is permitted. While a check is outstanding the tracker reports a stall. The requester keeps its address use asserted, unchanged, until the outcome is no longer a stall. When the response is installed in the bits, the outcome is decided again from the new bits on the next cycle.

The refresh controller has three states:

- `FS_IDLE`: no check outstanding. A use that needs a check moves it to `FS_ISSUE`.
- `FS_ISSUE`: the request is presented. Acceptance moves it to `FS_AWAIT`.
- `FS_AWAIT`: waiting for the response. A response returns it to `FS_IDLE` and installs the result, unless the register was overwritten meanwhile.

Top module: `ptr_flag_tracker`

## Requirements
- R1: After reset every register's checked, permitted and kind bits are clear, `status` is 00 and `chk_req_valid` is low.
- R2: `status` encodes 00 proceed, 01 stall, 10 trap, and 11 never appears. With `use_valid` low and no check outstanding, `status` is 00.
- R3: A use of register n (n not 0) whose checked bit is clear gives status 01 in that cycle. From the next cycle, `chk_req_valid` is raised with `chk_req_idx` = n and `chk_req_kind` = `use_kind`. The request and index are held until `chk_req_ready`. Status stays 01 until the response has been taken.
- R4: A response taken in state `FS_AWAIT` sets the register's checked bit, sets its permitted bit to `chk_rsp_ok`, and records the access kind. The held use then gets 00 if permitted and 10 if denied.
- R5: A use of a register whose checked bit is set with a matching kind (`use_kind` 0 data, 1 fetch) gives 00 if the permitted bit is set and 10 if it is clear, in the same cycle, and issues no request.
- R6: A register checked for one access kind counts as unchecked for the other kind, so such a use stalls and starts a new check.
- R7: A writeback of class 00 (ordinary) or 11 clears the checked and permitted bits of the written register.
- R8: A writeback of class 01 (post-increment) to register n (not 0) sets its checked bit, sets its permitted bit to `wb_ok`, and records `wb_kind`.
- R9: A writeback of class 10 (loop-entry/prefetch copy) gives the destination the source register's three bits. If the source is an immediate (`wb_src_imm`) or register 0, the destination bits are cleared.
- R10: A writeback to the register under check at any time while a check is outstanding, including the cycle of the response, wins over the response, and the bits stay clear.
- R11: Register 0 never holds set bits. A use of register 0 gives 10 without issuing a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_valid | input | 1 | A register is used as a memory address this cycle |
| use_idx | input | IDX_W | Index of the address register |
| use_kind | input | 1 | Access kind: 0 data, 1 instruction fetch |
| status | output | 2 | Outcome: 00 proceed, 01 stall, 10 trap |
| wb_valid | input | 1 | A register writeback occurs this cycle |
| wb_idx | input | IDX_W | Destination register of the writeback |
| wb_class | input | 2 | 00 ordinary, 01 post-increment, 10 copy, 11 ordinary |
| wb_src_idx | input | IDX_W | Source register for the copy class |
| wb_src_imm | input | 1 | Copy source is an immediate |
| wb_ok | input | 1 | Post-increment access was permitted |
| wb_kind | input | 1 | Access kind of the post-increment access |
| chk_req_valid | output | 1 | Translation check request |
| chk_req_ready | input | 1 | Request accepted |
| chk_req_idx | output | IDX_W | Register under check |
| chk_req_kind | output | 1 | Access kind to check |
| chk_rsp_valid | input | 1 | Check response present |
| chk_rsp_ok | input | 1 | Access permitted |

## Verification
The assertions assume three things about the environment. The requester keeps `use_valid`, `use_idx` and `use_kind` steady while `status` is 01. `chk_rsp_valid` comes only after a request has been accepted, and then exactly once. `wb_class` carries one of the four listed codes. The bench's responder model raises ready and the response only in answer to an observed request, with configurable delays. Each directed task holds its use until the stall ends. The deliberate conflict cases drop the use exactly at the response or accept cycle, which leaves the handshake order intact.

// File: rtl/ptrtrk_pkg.sv
package ptrtrk_pkg;

    typedef enum logic [1:0] {
        OUT_PROCEED = 2'b00,
        OUT_STALL   = 2'b01,
        OUT_TRAP    = 2'b10
    } outcome_e;

    typedef enum logic [1:0] {
        WB_PLAIN   = 2'b00,
        WB_POSTINC = 2'b01,
        WB_COPY    = 2'b10,
        WB_RSVD    = 2'b11
    } wb_class_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'b00,
        FS_ISSUE = 2'b01,
        FS_AWAIT = 2'b10
    } fsm_state_e;

    localparam logic KIND_DATA  = 1'b0;
    localparam logic KIND_FETCH = 1'b1;

endpackage

// File: rtl/ptrtrk_flag_store.sv
module ptrtrk_flag_store
    import ptrtrk_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    input  wb_class_e        wb_class,
    input  logic [IDX_W-1:0] wb_src_idx,
    input  logic             wb_src_imm,
    input  logic             wb_ok,
    input  logic             wb_kind,
    input  logic             inst_en,
    input  logic [IDX_W-1:0] inst_idx,
    input  logic             inst_ok,
    input  logic             inst_kind,
    output logic [NREGS-1:0] ptr_q,
    output logic [NREGS-1:0] vld_q,
    output logic [NREGS-1:0] knd_q
);

    // Source bits for the copy class, sampled before this cycle's update.
    logic src_ptr, src_vld, src_knd, src_usable;

    always_comb begin
        src_usable = !wb_src_imm && (wb_src_idx != '0);
        src_ptr    = src_usable && ptr_q[wb_src_idx];
        src_vld    = src_usable && vld_q[wb_src_idx];
        src_knd    = src_usable && knd_q[wb_src_idx];
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign ptr_q[g] = 1'b0;
            assign vld_q[g] = 1'b0;
            assign knd_q[g] = 1'b0;
        end else begin : g_live
            logic p_q, v_q, k_q;
            logic wb_hit, inst_hit;

            assign wb_hit   = wb_valid && (wb_idx == IDX_W'(g));
            assign inst_hit = inst_en && (inst_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    p_q <= 1'b0;
                    v_q <= 1'b0;
                    k_q <= 1'b0;
                end else if (wb_hit) begin
                    unique case (wb_class)
                        WB_POSTINC: begin
                            p_q <= 1'b1;
                            v_q <= wb_ok;
                            k_q <= wb_kind;
                        end
                        WB_COPY: begin
                            p_q <= src_ptr;
                            v_q <= src_vld;
                            k_q <= src_knd;
                        end
                        default: begin
                            p_q <= 1'b0;
                            v_q <= 1'b0;
                            k_q <= 1'b0;
                        end
                    endcase
                end else if (inst_hit) begin
                    p_q <= 1'b1;
                    v_q <= inst_ok;
                    k_q <= inst_kind;
                end
            end

            assign ptr_q[g] = p_q;
            assign vld_q[g] = v_q;
            assign knd_q[g] = k_q;
        end
    end

endmodule

// File: rtl/ptrtrk_outcome.sv
module ptrtrk_outcome
    import ptrtrk_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             use_valid,
    input  logic [IDX_W-1:0] use_idx,
    input  logic             use_kind,
    input  logic             busy,
    input  logic [NREGS-1:0] ptr_q,
    input  logic [NREGS-1:0] vld_q,
    input  logic [NREGS-1:0] knd_q,
    output logic             need_check,
    output outcome_e         outcome
);

    logic is_zero, kind_match, checked;

    always_comb begin
        is_zero    = (use_idx == '0);
        kind_match = (knd_q[use_idx] == use_kind);
        checked    = ptr_q[use_idx] && kind_match;
        need_check = use_valid && !busy && !is_zero && !checked;

        if (busy) begin
            outcome = OUT_STALL;
        end else if (!use_valid) begin
            outcome = OUT_PROCEED;
        end else if (is_zero) begin
            outcome = OUT_TRAP;
        end else if (!checked) begin
            outcome = OUT_STALL;
        end else if (vld_q[use_idx]) begin
            outcome = OUT_PROCEED;
        end else begin
            outcome = OUT_TRAP;
        end
    end

endmodule

// File: rtl/ptrtrk_refresh_fsm.sv
module ptrtrk_refresh_fsm
    import ptrtrk_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             start_kind,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    output logic             busy,
    output logic             req_valid,
    output logic [IDX_W-1:0] req_idx,
    output logic             req_kind,
    output logic             inst_en
);

    fsm_state_e       state_q, state_d;
    logic [IDX_W-1:0] pend_idx_q;
    logic             pend_kind_q;
    logic             stale_q;

    // State register and the captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FS_IDLE;
            pend_idx_q  <= '0;
            pend_kind_q <= 1'b0;
            stale_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                pend_idx_q  <= start_idx;
                pend_kind_q <= start_kind;
                stale_q     <= 1'b0;
            end else if ((state_q != FS_IDLE) && wb_valid && (wb_idx == pend_idx_q)) begin
                stale_q <= 1'b1;
            end
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (start)     state_d = FS_ISSUE;
            FS_ISSUE: if (req_ready) state_d = FS_AWAIT;
            FS_AWAIT: if (rsp_valid) state_d = FS_IDLE;
            default:                 state_d = FS_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        busy      = (state_q != FS_IDLE);
        req_valid = (state_q == FS_ISSUE);
        req_idx   = pend_idx_q;
        req_kind  = pend_kind_q;
        inst_en   = (state_q == FS_AWAIT) && rsp_valid && !stale_q;
    end

endmodule

// File: rtl/ptr_flag_tracker.sv
module ptr_flag_tracker
    import ptrtrk_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_valid,
    input  logic [IDX_W-1:0] use_idx,
    input  logic             use_kind,
    output logic [1:0]       status,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [1:0]       wb_class,
    input  logic [IDX_W-1:0] wb_src_idx,
    input  logic             wb_src_imm,
    input  logic             wb_ok,
    input  logic             wb_kind,
    output logic             chk_req_valid,
    input  logic             chk_req_ready,
    output logic [IDX_W-1:0] chk_req_idx,
    output logic             chk_req_kind,
    input  logic             chk_rsp_valid,
    input  logic             chk_rsp_ok
);

    logic [NREGS-1:0] ptr_w, vld_w, knd_w;
    logic             busy_w, need_check_w, inst_en_w;
    outcome_e         outcome_w;

    ptrtrk_flag_store #(.NREGS(NREGS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wb_valid   (wb_valid),
        .wb_idx     (wb_idx),
        .wb_class   (wb_class_e'(wb_class)),
        .wb_src_idx (wb_src_idx),
        .wb_src_imm (wb_src_imm),
        .wb_ok      (wb_ok),
        .wb_kind    (wb_kind),
        .inst_en    (inst_en_w),
        .inst_idx   (chk_req_idx),
        .inst_ok    (chk_rsp_ok),
        .inst_kind  (chk_req_kind),
        .ptr_q      (ptr_w),
        .vld_q      (vld_w),
        .knd_q      (knd_w)
    );

    ptrtrk_outcome #(.NREGS(NREGS)) decide_i (
        .use_valid  (use_valid),
        .use_idx    (use_idx),
        .use_kind   (use_kind),
        .busy       (busy_w),
        .ptr_q      (ptr_w),
        .vld_q      (vld_w),
        .knd_q      (knd_w),
        .need_check (need_check_w),
        .outcome    (outcome_w)
    );

    ptrtrk_refresh_fsm #(.NREGS(NREGS)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (need_check_w),
        .start_idx  (use_idx),
        .start_kind (use_kind),
        .req_ready  (chk_req_ready),
        .rsp_valid  (chk_rsp_valid),
        .wb_valid   (wb_valid),
        .wb_idx     (wb_idx),
        .busy       (busy_w),
        .req_valid  (chk_req_valid),
        .req_idx    (chk_req_idx),
        .req_kind   (chk_req_kind),
        .inst_en    (inst_en_w)
    );

    assign status = outcome_w;

endmodule

// File: rtl/ptrtrk_checker.sv
module ptrtrk_checker #(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             use_valid,
    input logic [IDX_W-1:0] use_idx,
    input logic [1:0]       status,
    input logic             wb_valid,
    input logic [IDX_W-1:0] wb_idx,
    input logic [1:0]       wb_class,
    input logic             wb_ok,
    input logic             chk_req_valid,
    input logic             chk_req_ready,
    input logic [IDX_W-1:0] chk_req_idx,
    input logic [NREGS-1:0] ptr_q,
    input logic [NREGS-1:0] vld_q,
    input logic             busy
);

    a_r2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req_valid && !chk_req_ready |=> chk_req_valid && $stable(chk_req_idx));

    a_r3_stall_during_req: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req_valid |-> status == 2'b01);

    a_r11_zero_traps: assert property (@(posedge clk) disable iff (!rst_n)
        use_valid && (use_idx == '0) && !busy |-> status == 2'b10);

    a_r11_zero_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_q[0] && !vld_q[0]);

    a_r7_plain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && (wb_class == 2'b00) |=> !ptr_q[$past(wb_idx)] && !vld_q[$past(wb_idx)]);

    a_r8_postinc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && (wb_class == 2'b01) && (wb_idx != '0)
        |=> ptr_q[$past(wb_idx)] && (vld_q[$past(wb_idx)] == $past(wb_ok)));

endmodule

bind ptr_flag_tracker ptrtrk_checker #(.NREGS(NREGS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .use_valid     (use_valid),
    .use_idx       (use_idx),
    .status        (status),
    .wb_valid      (wb_valid),
    .wb_idx        (wb_idx),
    .wb_class      (wb_class),
    .wb_ok         (wb_ok),
    .chk_req_valid (chk_req_valid),
    .chk_req_ready (chk_req_ready),
    .chk_req_idx   (chk_req_idx),
    .ptr_q         (ptr_w),
    .vld_q         (vld_w),
    .busy          (busy_w)
);

// File: tb/ptr_flag_tracker_tb_top.sv
module ptr_flag_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREGS = 32;
    localparam int IDX_W = $clog2(NREGS);
    localparam logic [1:0] S_GO = 2'b00, S_STALL = 2'b01, S_TRAP = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             use_valid = 1'b0;
    logic [IDX_W-1:0] use_idx = '0;
    logic             use_kind = 1'b0;
    logic [1:0]       status;
    logic             wb_valid = 1'b0;
    logic [IDX_W-1:0] wb_idx = '0;
    logic [1:0]       wb_class = 2'b00;
    logic [IDX_W-1:0] wb_src_idx = '0;
    logic             wb_src_imm = 1'b0;
    logic             wb_ok = 1'b0;
    logic             wb_kind = 1'b0;
    logic             chk_req_valid;
    logic             chk_req_ready = 1'b0;
    logic [IDX_W-1:0] chk_req_idx;
    logic             chk_req_kind;
    logic             chk_rsp_valid = 1'b0;
    logic             chk_rsp_ok = 1'b0;

    int checks = 0;
    int errors = 0;
    int rdy_cfg = 0;
    int lat_cfg = 1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_flag_tracker #(.NREGS(NREGS)) dut_i (.*);

    // Translation table model: register 6 is denied for data, 13 for fetch.
    function automatic logic permit(input int idx, input logic kind);
        if (idx == 6 && kind == 1'b0) return 1'b0;
        if (idx == 13 && kind == 1'b1) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Responder: answers requests on negative edges.
    initial begin
        int cnt = 0;
        bit pend = 0;
        int wait_rdy = 0;
        logic [IDX_W-1:0] cap_idx = '0;
        logic cap_kind = 1'b0;
        forever begin
            @(negedge clk);
            chk_rsp_valid = 1'b0;
            if (chk_req_ready) begin
                chk_req_ready = 1'b0;
                pend = 1;
                cnt = lat_cfg;
            end else if (pend) begin
                if (cnt == 0) begin
                    chk_rsp_valid = 1'b1;
                    chk_rsp_ok = permit(int'(cap_idx), cap_kind);
                    pend = 0;
                end else begin
                    cnt--;
                end
            end else if (chk_req_valid) begin
                if (wait_rdy < rdy_cfg) begin
                    wait_rdy++;
                end else begin
                    wait_rdy = 0;
                    chk_req_ready = 1'b1;
                    cap_idx = chk_req_idx;
                    cap_kind = chk_req_kind;
                end
            end
        end
    end

    task automatic use_reg(input int idx, input logic kind, input logic [1:0] first,
                           input logic [1:0] last, input string tag);
        int n = 0;
        @(negedge clk);
        use_valid = 1'b1;
        use_idx = IDX_W'(idx);
        use_kind = kind;
        #2;
        check(status == first, {tag, " first outcome"}, status, first);
        while (status == S_STALL && n < 60) begin
            if (chk_req_valid)
                check(chk_req_idx == IDX_W'(idx) && chk_req_kind == kind,
                      {tag, " R3 request index"}, chk_req_idx, idx);
            @(negedge clk);
            #2;
            n++;
        end
        check(status == last, {tag, " final outcome"}, status, last);
        if (first == last && first != S_STALL)
            check(n == 0, {tag, " no stall"}, n, 0);
        @(negedge clk);
        use_valid = 1'b0;
    endtask

    task automatic write_reg(input int idx, input logic [1:0] cls, input int src,
                             input logic imm, input logic ok, input logic kind);
        @(negedge clk);
        wb_valid = 1'b1;
        wb_idx = IDX_W'(idx);
        wb_class = cls;
        wb_src_idx = IDX_W'(src);
        wb_src_imm = imm;
        wb_ok = ok;
        wb_kind = kind;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic t_reset;
        #2;
        check(status == S_GO, "R1 reset status", status, 0);
        check(!chk_req_valid, "R1 reset request", chk_req_valid, 0);
        use_reg(3, 1'b0, S_STALL, S_GO, "R1 reset flags clear");
    endtask

    task automatic t_refresh;
        use_reg(5, 1'b0, S_STALL, S_GO, "R3 R4 permitted refresh");
        use_reg(5, 1'b0, S_GO, S_GO, "R5 cached proceed");
        use_reg(6, 1'b0, S_STALL, S_TRAP, "R4 denied refresh");
        use_reg(6, 1'b0, S_TRAP, S_TRAP, "R5 cached trap");
        @(negedge clk); #2;
        check(status == S_GO, "R2 idle status", status, 0);
    endtask

    task automatic t_slow_handshake;
        rdy_cfg = 3;
        lat_cfg = 4;
        use_reg(11, 1'b1, S_STALL, S_GO, "R3 slow ready");
        rdy_cfg = 0;
        lat_cfg = 1;
    endtask

    task automatic t_kind;
        use_reg(5, 1'b1, S_STALL, S_GO, "R6 fetch after data check");
        use_reg(5, 1'b0, S_STALL, S_GO, "R6 data after fetch check");
        use_reg(13, 1'b1, S_STALL, S_TRAP, "R6 fetch denied");
    endtask

    task automatic t_plain;
        write_reg(5, 2'b00, 0, 1'b0, 1'b0, 1'b0);
        use_reg(5, 1'b0, S_STALL, S_GO, "R7 ordinary write clears");
        write_reg(6, 2'b11, 0, 1'b0, 1'b0, 1'b0);
        use_reg(6, 1'b0, S_STALL, S_TRAP, "R7 class 11 clears");
    endtask

    task automatic t_postinc;
        write_reg(7, 2'b01, 0, 1'b0, 1'b1, 1'b0);
        use_reg(7, 1'b0, S_GO, S_GO, "R8 post-increment permitted");
        write_reg(9, 2'b01, 0, 1'b0, 1'b0, 1'b0);
        use_reg(9, 1'b0, S_TRAP, S_TRAP, "R8 post-increment denied");
    endtask

    task automatic t_copy;
        write_reg(8, 2'b10, 7, 1'b0, 1'b0, 1'b0);
        use_reg(8, 1'b0, S_GO, S_GO, "R9 copy from checked source");
        write_reg(8, 2'b10, 7, 1'b1, 1'b0, 1'b0);
        use_reg(8, 1'b0, S_STALL, S_GO, "R9 immediate source clears");
        write_reg(14, 2'b10, 9, 1'b0, 1'b0, 1'b0);
        use_reg(14, 1'b0, S_TRAP, S_TRAP, "R9 copy of denied source");
        write_reg(14, 2'b10, 0, 1'b0, 1'b0, 1'b0);
        use_reg(14, 1'b0, S_STALL, S_GO, "R9 register 0 source clears");
    endtask

    task automatic t_conflict;
        int n = 0;
        // same cycle as response
        lat_cfg = 2;
        @(negedge clk);
        use_valid = 1'b1; use_idx = IDX_W'(10); use_kind = 1'b0;
        #2;
        check(status == S_STALL, "R10 first stall", status, 1);
        while (!chk_rsp_valid && n < 40) begin @(negedge clk); #2; n++; end
        use_valid = 1'b0;
        wb_valid = 1'b1; wb_idx = IDX_W'(10); wb_class = 2'b00;
        @(negedge clk);
        wb_valid = 1'b0;
        use_reg(10, 1'b0, S_STALL, S_GO, "R10 same-cycle writeback wins");
        // earlier in the wait
        lat_cfg = 4;
        n = 0;
        @(negedge clk);
        use_valid = 1'b1; use_idx = IDX_W'(12); use_kind = 1'b0;
        while (!chk_req_ready && n < 40) begin @(negedge clk); #2; n++; end
        @(negedge clk);
        use_valid = 1'b0;
        wb_valid = 1'b1; wb_idx = IDX_W'(12); wb_class = 2'b00;
        @(negedge clk);
        wb_valid = 1'b0;
        n = 0;
        while (!chk_rsp_valid && n < 40) begin @(negedge clk); #2; n++; end
        @(negedge clk);
        lat_cfg = 1;
        use_reg(12, 1'b0, S_STALL, S_GO, "R10 writeback during wait wins");
    endtask

    task automatic t_zero;
        use_reg(0, 1'b0, S_TRAP, S_TRAP, "R11 register 0 traps");
        check(!chk_req_valid, "R11 no request for register 0", chk_req_valid, 0);
        write_reg(0, 2'b01, 0, 1'b0, 1'b1, 1'b0);
        use_reg(0, 1'b0, S_TRAP, S_TRAP, "R11 post-increment to register 0");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_refresh();
        t_slow_handshake();
        t_kind();
        t_plain();
        t_postinc();
        t_copy();
        t_conflict();
        t_zero();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule